// File: doc/BRIEF.md
# MESI Snoop Line-State Controller

This block holds the coherence state of a small direct-mapped set of cache lines. It serves one processor port and one bus-snoop port. For each processor read or write it looks up the addressed slot and does one of two things. It completes the access at once, or it raises one bus request and waits for the bus to finish it. The request is a line read, a read-for-ownership, an upgrade that invalidates other copies, or a write-back of a dirty victim. Each slot is Modified, Exclusive, Shared or Invalid.

The snoop port observes a transaction from another agent each cycle. That transaction is a plain read or an intent-to-write. The block answers in the same cycle with a shared indication, a write-back request and a data-intervention request, and it updates the matching slot at the next clock edge. A read fill becomes Exclusive when the bus reports no other copy, so a later write to private data needs no bus traffic. Data arrays, memory timing and arbitration stay outside the block. They are seen only through the request/done handshake.

Addresses are line addresses. The low `IDX_W` bits select the slot and the rest form the tag. The processor holds its request until `cpu_done`.

The controller has three states:
- `CTL_IDLE` evaluates the processor request. It moves to `CTL_EVICT` on a miss whose victim is Modified, and to `CTL_FETCH` on any other miss or on a write to a Shared line.
- Both `CTL_EVICT` and `CTL_FETCH` return to `CTL_IDLE` on `bus_done`, or when a snoop to the same slot withdraws the request.

Top module: `mesi_snoop_ctl`

## Requirements
- R1: After reset every slot is Invalid. A snoop then gets no response, and the first processor access to any address misses.
- R2: A read that hits a Shared, Exclusive or Modified slot raises `cpu_done` in the cycle the request is evaluated, and raises no bus request.
- R3: A read miss requests a line read (`bus_req_op` = 0) for the requested address. At `bus_done` the slot is filled as Exclusive if `bus_shared` is low and as Shared if it is high.
- R4: A write that hits an Exclusive slot completes at once and makes it Modified with no bus request. A write that hits a Modified slot completes at once and leaves it Modified.
- R5: A write that hits a Shared slot first requests an upgrade (`bus_req_op` = 2). At `bus_done` the slot becomes Modified.
- R6: A write miss requests a read-for-ownership (`bus_req_op` = 1), and at `bus_done` the slot becomes Modified.
- R7: A miss whose slot holds a Modified line with another tag first requests a write-back (`bus_req_op` = 3) with address {victim tag, slot}. At `bus_done` the slot becomes Invalid, and the miss is then served as in R3/R6.
- R8: A snooped read (`snp_excl` = 0) that hits a Modified slot raises `snp_wb` and `snp_supply`, and the slot becomes Shared. One that hits an Exclusive slot raises neither, and the slot becomes Shared.
- R9: `snp_shared` is high exactly when a snooped read hits a slot in Shared, Exclusive or Modified state.
- R10: A snooped intent-to-write (`snp_excl` = 1) that hits makes the slot Invalid. It raises `snp_wb` when the slot was Modified, and it never raises `snp_shared` or `snp_supply`.
- R11: When a snoop addresses the same slot as the processor request, or as a pending bus request, in the same cycle, the snoop is applied first. In that cycle `cpu_done` stays low and no new request starts, and a pending request is withdrawn. The processor request is evaluated again in the next cycle. A snoop to another slot does not stall the processor.
- R12: A bus request keeps `bus_req_valid`, `bus_req_op` and `bus_req_addr` stable until `bus_done`, unless it is withdrawn under R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_done | output | 1 | Access completes in this cycle |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_done | input | 1 | Bus has completed the pending request |
| bus_shared | input | 1 | Another cache holds the line (sampled with bus_done) |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_excl | input | 1 | 1 = intent-to-write, 0 = read |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped line |
| snp_wb | output | 1 | Dirty line must be written back |
| snp_supply | output | 1 | This cache supplies the line data |

## Verification
The snoop port and the processor port can address the same slot in the same cycle. This can happen while a processor request is first evaluated, and again while its bus request is pending. Directed cases line up a hit or a write-upgrade with a snoop to the same slot. Random runs inject snoops, to either the requested tag or the victim tag, into cycles where a request is pending. The bench judges each such cycle against its own line-state model. It expects `cpu_done` low and the snoop answers taken from the pre-snoop state. It expects the request dropped in the next cycle and then re-issued as the updated state dictates.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        BOP_RD   = 2'b00,
        BOP_RDX  = 2'b01,
        BOP_UPGR = 2'b10,
        BOP_WB   = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'b00,
        CTL_EVICT = 2'b01,
        CTL_FETCH = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    a_idx,
    output logic [TAG_W-1:0]    a_tag,
    output line_state_e         a_st,
    input  logic [IDX_W-1:0]    b_idx,
    output logic [TAG_W-1:0]    b_tag,
    output line_state_e         b_st,
    input  logic                snp_we,
    input  logic [IDX_W-1:0]    snp_idx,
    input  line_state_e         snp_st,
    input  logic                cpu_we,
    input  logic [IDX_W-1:0]    cpu_idx,
    input  logic [TAG_W-1:0]    cpu_tag,
    input  line_state_e         cpu_st
);
    localparam int LINES = 1 << IDX_W;

    line_state_e        st_q  [LINES];
    logic [TAG_W-1:0]   tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_e        st_r;
        logic [TAG_W-1:0]   tag_r;

        // Snoop updates win over processor updates to the same slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LS_INV;
                tag_r <= '0;
            end else if (snp_we && (snp_idx == IDX_W'(g))) begin
                st_r  <= snp_st;
            end else if (cpu_we && (cpu_idx == IDX_W'(g))) begin
                st_r  <= cpu_st;
                tag_r <= cpu_tag;
            end
        end

        assign st_q[g]  = st_r;
        assign tag_q[g] = tag_r;
    end

    assign a_tag = tag_q[a_idx];
    assign a_st  = st_q[a_idx];
    assign b_tag = tag_q[b_idx];
    assign b_st  = st_q[b_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic                snp_valid,
    input  logic                snp_excl,
    input  logic [TAG_W-1:0]    snp_tag,
    input  logic [TAG_W-1:0]    line_tag,
    input  line_state_e         line_st,
    output logic                hit,
    output logic                shared,
    output logic                wb,
    output logic                supply,
    output line_state_e         next_st
);
    always_comb begin
        hit     = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
        shared  = 1'b0;
        wb      = 1'b0;
        supply  = 1'b0;
        next_st = line_st;
        if (hit) begin
            if (snp_excl) begin
                wb      = (line_st == LS_MOD);
                next_st = LS_INV;
            end else begin
                shared  = 1'b1;
                wb      = (line_st == LS_MOD);
                supply  = (line_st == LS_MOD);
                next_st = LS_SHR;
            end
        end
    end

endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic [TAG_W-1:0]    cpu_tag,
    input  logic [IDX_W-1:0]    cpu_idx,
    input  logic [TAG_W-1:0]    line_tag,
    input  line_state_e         line_st,
    input  logic                snp_valid,
    input  logic [IDX_W-1:0]    snp_idx,
    input  logic                bus_done,
    input  logic                bus_shared,
    output logic                cpu_done,
    output logic                bus_req_valid,
    output bus_op_e             bus_req_op,
    output logic [TAG_W-1:0]    bus_req_tag,
    output logic [IDX_W-1:0]    bus_req_idx,
    output logic                upd_we,
    output logic [IDX_W-1:0]    upd_idx,
    output logic [TAG_W-1:0]    upd_tag,
    output line_state_e         upd_st
);
    ctl_state_e         state_q, state_d;
    bus_op_e            op_q, op_d;
    logic [TAG_W-1:0]   tag_q, tag_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    logic hit, clash_idle, clash_wait;

    assign hit        = (line_st != LS_INV) && (line_tag == cpu_tag);
    assign clash_idle = snp_valid && (snp_idx == cpu_idx);
    assign clash_wait = snp_valid && (snp_idx == idx_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
            op_q    <= BOP_RD;
            tag_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            tag_q   <= tag_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        tag_d    = tag_q;
        idx_d    = idx_q;
        cpu_done = 1'b0;
        upd_we   = 1'b0;
        upd_idx  = idx_q;
        upd_tag  = tag_q;
        upd_st   = LS_INV;
        unique case (state_q)
            CTL_IDLE: begin
                if (cpu_valid && !clash_idle) begin
                    idx_d = cpu_idx;
                    if (hit && (!cpu_write || (line_st != LS_SHR))) begin
                        cpu_done = 1'b1;
                        if (cpu_write && (line_st == LS_EXC)) begin
                            upd_we  = 1'b1;
                            upd_idx = cpu_idx;
                            upd_tag = cpu_tag;
                            upd_st  = LS_MOD;
                        end
                    end else if (hit) begin
                        state_d = CTL_FETCH;
                        op_d    = BOP_UPGR;
                        tag_d   = cpu_tag;
                    end else if (line_st == LS_MOD) begin
                        state_d = CTL_EVICT;
                        op_d    = BOP_WB;
                        tag_d   = line_tag;
                    end else begin
                        state_d = CTL_FETCH;
                        op_d    = cpu_write ? BOP_RDX : BOP_RD;
                        tag_d   = cpu_tag;
                    end
                end
            end
            CTL_EVICT, CTL_FETCH: begin
                if (clash_wait) begin
                    state_d = CTL_IDLE;
                end else if (bus_done) begin
                    state_d = CTL_IDLE;
                    upd_we  = 1'b1;
                    unique case (op_q)
                        BOP_WB:  upd_st = LS_INV;
                        BOP_RD:  upd_st = bus_shared ? LS_SHR : LS_EXC;
                        default: upd_st = LS_MOD;
                    endcase
                end
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    assign bus_req_valid = (state_q != CTL_IDLE);
    assign bus_req_op    = op_q;
    assign bus_req_tag   = tag_q;
    assign bus_req_idx   = idx_q;

endmodule

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic [ADDR_W-1:0]   cpu_addr,
    output logic                cpu_done,
    output logic                bus_req_valid,
    output logic [1:0]          bus_req_op,
    output logic [ADDR_W-1:0]   bus_req_addr,
    input  logic                bus_done,
    input  logic                bus_shared,
    input  logic                snp_valid,
    input  logic                snp_excl,
    input  logic [ADDR_W-1:0]   snp_addr,
    output logic                snp_shared,
    output logic                snp_wb,
    output logic                snp_supply
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]   cpu_idx, snp_idx, req_idx, upd_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag, req_tag, upd_tag;
    logic [TAG_W-1:0]   a_tag, b_tag;
    line_state_e        a_st, b_st, snp_next, upd_st;
    bus_op_e            req_op;
    logic               snp_hit, upd_we;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (cpu_idx),
        .a_tag   (a_tag),
        .a_st    (a_st),
        .b_idx   (snp_idx),
        .b_tag   (b_tag),
        .b_st    (b_st),
        .snp_we  (snp_hit),
        .snp_idx (snp_idx),
        .snp_st  (snp_next),
        .cpu_we  (upd_we),
        .cpu_idx (upd_idx),
        .cpu_tag (upd_tag),
        .cpu_st  (upd_st)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W)) snoop_i (
        .snp_valid (snp_valid),
        .snp_excl  (snp_excl),
        .snp_tag   (snp_tag),
        .line_tag  (b_tag),
        .line_st   (b_st),
        .hit       (snp_hit),
        .shared    (snp_shared),
        .wb        (snp_wb),
        .supply    (snp_supply),
        .next_st   (snp_next)
    );

    mesi_cpu_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_valid     (cpu_valid),
        .cpu_write     (cpu_write),
        .cpu_tag       (cpu_tag),
        .cpu_idx       (cpu_idx),
        .line_tag      (a_tag),
        .line_st       (a_st),
        .snp_valid     (snp_valid),
        .snp_idx       (snp_idx),
        .bus_done      (bus_done),
        .bus_shared    (bus_shared),
        .cpu_done      (cpu_done),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (req_op),
        .bus_req_tag   (req_tag),
        .bus_req_idx   (req_idx),
        .upd_we        (upd_we),
        .upd_idx       (upd_idx),
        .upd_tag       (upd_tag),
        .upd_st        (upd_st)
    );

    assign bus_req_op   = req_op;
    assign bus_req_addr = {req_tag, req_idx};

endmodule

// File: rtl/mesi_snoop_ctl_chk.sv
module mesi_snoop_ctl_chk #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_valid,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic                 cpu_done,
    input logic                 bus_req_valid,
    input logic [1:0]           bus_req_op,
    input logic [ADDR_W-1:0]    bus_req_addr,
    input logic                 bus_done,
    input logic                 snp_valid,
    input logic                 snp_excl,
    input logic [ADDR_W-1:0]    snp_addr,
    input logic                 snp_shared,
    input logic                 snp_wb,
    input logic                 snp_supply
);
    logic clash_cpu, clash_req;
    assign clash_cpu = snp_valid && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
    assign clash_req = snp_valid && (snp_addr[IDX_W-1:0] == bus_req_addr[IDX_W-1:0]);

    // R11
    conflict_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && clash_cpu |-> !cpu_done);

    // R11
    req_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && clash_req |=> !bus_req_valid);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_done && !clash_req |=>
            bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr));

    // R2
    done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req_valid);

    // R8
    supply_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_wb && snp_shared);

    // R10
    excl_no_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_excl |-> !snp_shared && !snp_supply);

    // R9
    snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |-> !snp_shared && !snp_wb && !snp_supply);

    // R7
    wb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && cpu_valid && (bus_req_op == 2'b11) |->
            bus_req_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

endmodule

bind mesi_snoop_ctl mesi_snoop_ctl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_addr      (cpu_addr),
    .cpu_done      (cpu_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .bus_req_addr  (bus_req_addr),
    .bus_done      (bus_done),
    .snp_valid     (snp_valid),
    .snp_excl      (snp_excl),
    .snp_addr      (snp_addr),
    .snp_shared    (snp_shared),
    .snp_wb        (snp_wb),
    .snp_supply    (snp_supply)
);

// File: tb/mesi_snoop_ctl_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_ctl_tb_top;
    localparam int AW = 6;
    localparam int IW = 3;
    localparam int TW = AW - IW;
    localparam int NL = 1 << IW;

    localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;
    localparam logic [1:0] OP_RD = 2'd0, OP_RDX = 2'd1, OP_UP = 2'd2, OP_WB = 2'd3;

    logic clk = 1'b0;
    logic rst_n;
    logic cpu_valid, cpu_write, cpu_done;
    logic [AW-1:0] cpu_addr;
    logic bus_req_valid, bus_done, bus_shared;
    logic [1:0] bus_req_op;
    logic [AW-1:0] bus_req_addr;
    logic snp_valid, snp_excl, snp_shared, snp_wb, snp_supply;
    logic [AW-1:0] snp_addr;

    logic [1:0]    m_st  [NL];
    logic [TW-1:0] m_tag [NL];

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mesi_snoop_ctl #(.ADDR_W(AW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
        .bus_done(bus_done), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_wb(snp_wb), .snp_supply(snp_supply)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            OP_RD:   return "R3";
            OP_RDX:  return "R6";
            OP_UP:   return "R5";
            default: return "R7";
        endcase
    endfunction

    // Expected reaction of an idle controller to a processor request.
    task automatic plan_cpu(input logic wr, input logic [AW-1:0] a,
                            output bit complete, output logic [1:0] op, output logic [AW-1:0] ea);
        logic [IW-1:0] ix;
        logic [TW-1:0] tg;
        bit h;
        ix = a[IW-1:0];
        tg = a[AW-1:IW];
        h = (m_st[ix] != S_I) && (m_tag[ix] == tg);
        complete = 1'b0;
        op = OP_RD;
        ea = a;
        if (h && (!wr || m_st[ix] != S_S)) complete = 1'b1;
        else if (h) op = OP_UP;
        else if (m_st[ix] == S_M) begin op = OP_WB; ea = {m_tag[ix], ix}; end
        else op = wr ? OP_RDX : OP_RD;
    endtask

    // Check snoop answers against the model, then update the model.
    task automatic snoop_check(input logic ex, input logic [AW-1:0] a);
        logic [IW-1:0] ix;
        bit h;
        ix = a[IW-1:0];
        h = (m_st[ix] != S_I) && (m_tag[ix] == a[AW-1:IW]);
        chk("R9", "snp_shared", int'(snp_shared), int'(h && !ex));
        chk(ex ? "R10" : "R8", "snp_wb", int'(snp_wb), int'(h && m_st[ix] == S_M));
        chk("R8", "snp_supply", int'(snp_supply), int'(h && !ex && m_st[ix] == S_M));
        if (h) m_st[ix] = ex ? S_I : S_S;
    endtask

    task automatic do_snoop(input logic ex, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_excl = ex; snp_addr = a;
        #1;
        snoop_check(ex, a);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // sh: 0 = no other copy, 1 = shared, 2 = random. inj: allow snoop injection.
    task automatic cpu_access(input logic wr, input logic [AW-1:0] a, input int sh, input bit inj_ok);
        bit pend, fin, inj, give, complete, from_inj;
        int waitc, delay;
        logic [1:0] pop, eop;
        logic [AW-1:0] paddr, ea;
        logic [IW-1:0] ix;
        logic shv;
        pend = 0; fin = 0; from_inj = 0; waitc = 0; delay = 0;
        pop = OP_RD; paddr = '0;
        ix = a[IW-1:0];
        for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
            inj = pend && inj_ok && ($urandom % 6 == 0);
            snp_valid = inj;
            snp_excl = 1'($urandom % 2);
            snp_addr = ($urandom % 2 == 0) ? a : {m_tag[ix], ix};
            give = pend && !inj && (waitc >= delay);
            shv = (sh == 2) ? 1'($urandom % 2) : 1'(sh);
            bus_done = give; bus_shared = shv;
            #1;
            if (!pend) begin
                plan_cpu(wr, a, complete, eop, ea);
                if (complete) begin
                    chk(from_inj ? "R11" : (wr ? "R4" : "R2"), "cpu_done on hit", int'(cpu_done), 1);
                    chk(wr ? "R4" : "R2", "no bus request on hit", int'(bus_req_valid), 0);
                    if (wr) m_st[ix] = S_M;
                    fin = 1;
                end else begin
                    chk(from_inj ? "R11" : op_req(eop), "cpu_done on miss", int'(cpu_done), 0);
                    chk(from_inj ? "R11" : op_req(eop), "request idle in decide cycle", int'(bus_req_valid), 0);
                    pend = 1; pop = eop; paddr = ea; waitc = 0; delay = int'($urandom % 3);
                end
                from_inj = 0;
            end else begin
                chk("R12", "bus_req_valid held", int'(bus_req_valid), 1);
                chk(op_req(pop), "bus_req_op", int'(bus_req_op), int'(pop));
                chk(op_req(pop), "bus_req_addr", int'(bus_req_addr), int'(paddr));
                chk("R12", "cpu_done while pending", int'(cpu_done), 0);
                if (inj) begin
                    snoop_check(snp_excl, snp_addr);
                    pend = 0; from_inj = 1;
                end else if (give) begin
                    case (pop)
                        OP_WB: m_st[ix] = S_I;
                        OP_RD: begin m_tag[ix] = paddr[AW-1:IW]; m_st[ix] = shv ? S_S : S_E; end
                        default: begin m_tag[ix] = paddr[AW-1:IW]; m_st[ix] = S_M; end
                    endcase
                    pend = 0;
                end else begin
                    waitc++;
                end
            end
        end
        if (!fin) chk("R2", "access never completed", 0, 1);
        @(negedge clk);
        cpu_valid = 1'b0; snp_valid = 1'b0; bus_done = 1'b0;
    endtask

    // Processor request and snoop in the same cycle; the caller follows with cpu_access.
    task automatic conflict(input logic wr, input logic [AW-1:0] ca, input logic ex, input logic [AW-1:0] sa);
        bit complete;
        logic [1:0] eop;
        logic [AW-1:0] ea;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = ca;
        snp_valid = 1'b1; snp_excl = ex; snp_addr = sa;
        #1;
        if (ca[IW-1:0] == sa[IW-1:0]) begin
            chk("R11", "cpu_done stalled by snoop", int'(cpu_done), 0);
            chk("R11", "no request on clash", int'(bus_req_valid), 0);
            snoop_check(ex, sa);
        end else begin
            plan_cpu(wr, ca, complete, eop, ea);
            chk("R11", "other-slot snoop does not stall", int'(cpu_done), int'(complete));
            if (complete && wr) m_st[ca[IW-1:0]] = S_M;
            snoop_check(ex, sa);
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin m_st[i] = S_I; m_tag[i] = '0; end
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0;
        bus_done = 1'b0; bus_shared = 1'b0;
        snp_valid = 1'b0; snp_excl = 1'b0; snp_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "cpu_done after reset", int'(cpu_done), 0);
        chk("R1", "bus_req_valid after reset", int'(bus_req_valid), 0);
        @(negedge clk);
        snp_valid = 1'b1; snp_excl = 1'b0; snp_addr = 6'o00;
        #1;
        chk("R1", "snoop after reset: shared", int'(snp_shared), 0);
        chk("R1", "snoop after reset: wb", int'(snp_wb), 0);
        @(negedge clk);
        snp_valid = 1'b0;

        // Directed sequence (address = {tag, slot} in octal)
        cpu_access(1'b0, 6'o01, 0, 0);   // R1/R3: miss, fill Exclusive
        cpu_access(1'b0, 6'o01, 0, 0);   // R2: read hit
        cpu_access(1'b1, 6'o01, 0, 0);   // R4: E -> M silently
        cpu_access(1'b1, 6'o01, 0, 0);   // R4: M write hit
        do_snoop(1'b0, 6'o01);           // R8: M read -> wb, supply, S
        cpu_access(1'b1, 6'o01, 0, 0);   // R5: upgrade -> M
        do_snoop(1'b1, 6'o01);           // R10: M -> I with wb
        cpu_access(1'b0, 6'o02, 1, 0);   // R3: fill Shared
        do_snoop(1'b0, 6'o02);           // R9: shared, no wb
        cpu_access(1'b1, 6'o02, 0, 0);   // R5
        cpu_access(1'b1, 6'o03, 0, 0);   // R6: RFO -> M
        cpu_access(1'b0, 6'o13, 0, 0);   // R7: write back victim, then read
        do_snoop(1'b0, 6'o13);           // R8: E -> S, no wb
        cpu_access(1'b1, 6'o13, 0, 0);   // R5
        do_snoop(1'b1, 6'o23);           // R10: different tag, no effect
        cpu_access(1'b1, 6'o13, 0, 0);   // still M: hit

        // R11 conflicts
        cpu_access(1'b1, 6'o04, 0, 0);
        conflict(1'b0, 6'o04, 1'b0, 6'o04);
        cpu_access(1'b0, 6'o04, 0, 0);
        conflict(1'b1, 6'o04, 1'b1, 6'o14);
        cpu_access(1'b1, 6'o04, 0, 0);
        conflict(1'b1, 6'o04, 1'b1, 6'o04);
        cpu_access(1'b1, 6'o04, 0, 0);
        conflict(1'b0, 6'o04, 1'b0, 6'o05);
        cpu_access(1'b0, 6'o04, 0, 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] ra;
            ra = {3'($urandom % 4), 3'($urandom % NL)};
            if ($urandom % 10 < 6) cpu_access(1'($urandom % 2), ra, 2, 1);
            else do_snoop(1'($urandom % 2), ra);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule